// File: doc/BRIEF.md
# Stack Pointer and Data Address Unit

This block sits in the memory stage of a pipelined processor. It keeps the stack pointer and, for each memory-stage operation, produces the data memory address, the read and write strobes and the write data. Four operations reach memory. A push stores a register at the current stack pointer and then moves the pointer down. A pop first moves the pointer up and then reads from the new location. A displacement load and a displacement store both address memory at a base register plus a signed 16-bit offset.

The address and strobe outputs are combinational from the operation inputs and the current stack pointer. They are meant to drive a synchronous data memory in the same cycle. The stack pointer register changes at the clock edge that ends a push or a pop. The pointer moves in steps of `STEP` (2 by default) and wraps modulo 2^`ADDR_W`. The data memory itself lies outside this block.

Top module: `stk_addr_unit`

## Requirements
- R1: While `rst` is high, `mem_re_o` and `mem_we_o` are 0 whatever the operation. One clock edge with `rst` high sets `sp_o` to 2^ADDR_W − STEP (0xFFE with the defaults).
- R2: For a push (`op_i` = 1), `mem_addr_o` equals the current `sp_o`, `mem_we_o` is 1, `mem_re_o` is 0 and `mem_wdata_o` equals `store_data_i`.
- R3: After the clock edge that ends a push, `sp_o` is its previous value minus STEP.
- R4: For a pop (`op_i` = 2), `mem_addr_o` equals `sp_o` + STEP, `mem_re_o` is 1 and `mem_we_o` is 0. After the clock edge, `sp_o` holds that same address.
- R5: For a displacement load (`op_i` = 3), `mem_addr_o` is the low ADDR_W bits of `base_i` plus the offset, `mem_re_o` is 1 and `mem_we_o` is 0.
- R6: For a displacement store (`op_i` = 4), `mem_addr_o` is formed in the same way as for R5, `mem_we_o` is 1, `mem_re_o` is 0 and `mem_wdata_o` equals `store_data_i`.
- R7: The offset is sign-extended, so an offset with bit 15 set lowers the address (0xFFFF means −1).
- R8: `mem_re_o` and `mem_we_o` are never both 1.
- R9: For idle (`op_i` = 0) and for the unused codes 5 to 7, both strobes and `mem_wdata_o` are 0. `sp_o` keeps its value for these codes and also for loads and stores.
- R10: Stack pointer arithmetic wraps modulo 2^ADDR_W. A push at 0 gives 2^ADDR_W − STEP, and a pop at 2^ADDR_W − STEP gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code: 0 idle, 1 push, 2 pop, 3 load, 4 store |
| base_i | input | DATA_W | Base register value for displacement access |
| offset_i | input | OFF_W | Signed displacement taken from instruction bits 15:0 |
| store_data_i | input | DATA_W | Register value to be written to memory |
| mem_addr_o | output | ADDR_W | Data memory address |
| mem_re_o | output | 1 | Data memory read enable |
| mem_we_o | output | 1 | Data memory write enable |
| mem_wdata_o | output | DATA_W | Data memory write data |
| sp_o | output | ADDR_W | Current stack pointer |

## Verification
Some properties are checked in every cycle: the two strobes never overlap, a push or pop moves the pointer by exactly one step, the pointer holds still for every other code, and a push addresses the live pointer. Other behaviour appears only in the bench scenarios. These cover last-in first-out data order through a memory model, a full push sweep that wraps past address zero and the pops back, and load and store addresses around the sign boundary of the offset, including bases wider than the address.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE  = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4
    } stk_op_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic load;
        logic store;
    } stk_ctl_t;

    function automatic stk_ctl_t stk_decode(input logic [OP_W-1:0] code);
        stk_ctl_t c;
        c = '0;
        case (code)
            OP_PUSH:  c.push  = 1'b1;
            OP_POP:   c.pop   = 1'b1;
            OP_LOAD:  c.load  = 1'b1;
            OP_STORE: c.store = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

    function automatic logic stk_reads(input stk_ctl_t c);
        return c.pop | c.load;
    endfunction

    function automatic logic stk_writes(input stk_ctl_t c);
        return c.push | c.store;
    endfunction

    function automatic logic stk_moves_sp(input stk_ctl_t c);
        return c.push | c.pop;
    endfunction

endpackage

// File: rtl/stk_sp_reg.sv
module stk_sp_reg
    import stk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_ctl_t          ctl,
    output logic [ADDR_W-1:0] sp_q,
    output logic [ADDR_W-1:0] sp_above
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
    localparam logic [ADDR_W-1:0] SP_TOP = '1 - ADDR_W'(STEP - 1);

    logic [ADDR_W-1:0] sp_below;

    assign sp_above = sp_q + STEP_V;
    assign sp_below = sp_q - STEP_V;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= SP_TOP;
        end else if (ctl.push) begin
            sp_q <= sp_below;
        end else if (ctl.pop) begin
            sp_q <= sp_above;
        end
    end

    // R1
    sp_reset_top_chk: assert property (@(posedge clk)
        rst |=> sp_q == SP_TOP);

    // R3
    sp_push_step_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.push |=> sp_q == $past(sp_q) - STEP_V);

    // R4
    sp_pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.pop |=> sp_q == $past(sp_q) + STEP_V);

    // R9
    sp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stk_moves_sp(ctl) |=> $stable(sp_q));

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16,
    parameter int ADDR_W = 12
) (
    input  logic [DATA_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] eff_addr
);
    logic [ADDR_W-1:0] off_ext;

    generate
        if (OFF_W >= ADDR_W) begin : g_trunc
            assign off_ext = offset[ADDR_W-1:0];
        end else begin : g_sext
            assign off_ext = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        end
    endgenerate

    assign eff_addr = base[ADDR_W-1:0] + off_ext;

endmodule

// File: rtl/stk_mem_ctrl.sv
module stk_mem_ctrl
    import stk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_ctl_t          ctl,
    input  logic [ADDR_W-1:0] sp_q,
    input  logic [ADDR_W-1:0] sp_above,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [DATA_W-1:0] store_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);
    always_comb begin
        mem_addr  = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        if (!rst) begin
            if (ctl.push) begin
                mem_addr  = sp_q;
                mem_we    = 1'b1;
                mem_wdata = store_data;
            end else if (ctl.pop) begin
                mem_addr  = sp_above;
                mem_re    = 1'b1;
            end else if (ctl.load) begin
                mem_addr  = eff_addr;
                mem_re    = 1'b1;
            end else if (ctl.store) begin
                mem_addr  = eff_addr;
                mem_we    = 1'b1;
                mem_wdata = store_data;
            end
        end
    end

    // R8
    rw_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we));

    // R2
    push_at_sp_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.push |-> (mem_we && mem_addr == sp_q));

    // R4
    pop_lands_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.pop |=> sp_q == $past(mem_addr));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(stk_reads(ctl) || stk_writes(ctl)) |-> (!mem_re && !mem_we && mem_wdata == '0));

endmodule

// File: rtl/stk_addr_unit.sv
module stk_addr_unit
    import stk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16,
    parameter int ADDR_W = 12,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [DATA_W-1:0] store_data_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [ADDR_W-1:0] sp_o
);
    stk_ctl_t          ctl;
    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] sp_above;
    logic [ADDR_W-1:0] eff_addr;

    assign ctl  = stk_decode(op_i);
    assign sp_o = sp_q;

    stk_sp_reg #(
        .ADDR_W (ADDR_W),
        .STEP   (STEP)
    ) sp_reg_i (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .sp_q     (sp_q),
        .sp_above (sp_above)
    );

    stk_addr_gen #(
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W),
        .ADDR_W (ADDR_W)
    ) addr_gen_i (
        .base     (base_i),
        .offset   (offset_i),
        .eff_addr (eff_addr)
    );

    stk_mem_ctrl #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) mem_ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .sp_q       (sp_q),
        .sp_above   (sp_above),
        .eff_addr   (eff_addr),
        .store_data (store_data_i),
        .mem_addr   (mem_addr_o),
        .mem_re     (mem_re_o),
        .mem_we     (mem_we_o),
        .mem_wdata  (mem_wdata_o)
    );

endmodule

// File: tb/stk_addr_unit_tb_top.sv
`timescale 1ns/1ps
module stk_addr_unit_tb_top;
    localparam int AW    = 12;
    localparam int DW    = 32;
    localparam int WORDS = 1 << (AW - 1);
    localparam logic [AW-1:0] TOP = 12'hFFE;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    op_r = 3'd0;
    logic [DW-1:0] base_r = '0;
    logic [15:0]   off_r = '0;
    logic [DW-1:0] data_r = '0;
    logic [AW-1:0] mem_addr_o;
    logic          mem_re_o, mem_we_o;
    logic [DW-1:0] mem_wdata_o;
    logic [AW-1:0] sp_o;

    int vectors = 0;
    int fails = 0;

    logic [DW-1:0] model  [WORDS];
    logic [DW-1:0] shadow [WORDS];

    always #4 clk = ~clk;

    stk_addr_unit dut_i (
        .clk(clk), .rst(rst), .op_i(op_r), .base_i(base_r), .offset_i(off_r),
        .store_data_i(data_r), .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o),
        .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .sp_o(sp_o)
    );

    always @(posedge clk) begin
        if (!rst && mem_we_o) model[mem_addr_o[AW-1:1]] <= mem_wdata_o;
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp_v);
        vectors++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [DW-1:0] b,
                         input logic [15:0] o, input logic [DW-1:0] d);
        @(negedge clk);
        op_r = op; base_r = b; off_r = o; data_r = d;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] ea(input logic [DW-1:0] b, input logic [15:0] o);
        logic [DW-1:0] s;
        s = b + {{16{o[15]}}, o};
        return s[AW-1:0];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] exp_sp;
        logic [DW-1:0] bases [5];
        logic [15:0]   offs  [9];
        bases = '{32'h0, 32'h10, 32'hFFE, 32'h1234_5678, 32'hFFFF_FFF0};
        offs  = '{16'h0, 16'h2, 16'h7FFE, 16'h7FFF, 16'h8000, 16'h8002,
                  16'hFFFE, 16'hFFFF, 16'h0100};

        // R1: strobes low during reset even with a push requested
        drive(3'd1, 0, 0, 32'hDEAD_BEEF);
        tick();
        chk("R1 re in reset", {31'b0, mem_re_o}, 0);
        chk("R1 we in reset", {31'b0, mem_we_o}, 0);
        chk("R1 sp reset", {20'b0, sp_o}, {20'b0, TOP});
        drive(3'd0, 0, 0, 0);
        rst = 1'b0;
        exp_sp = TOP;

        // R9: idle and unused codes
        for (int c = 0; c < 8; c++) begin
            if (c >= 1 && c <= 4) continue;
            drive(3'(c), 32'h55, 16'h3, 32'hFFFF_FFFF);
            chk("R9 re idle", {31'b0, mem_re_o}, 0);
            chk("R9 we idle", {31'b0, mem_we_o}, 0);
            chk("R9 wdata idle", mem_wdata_o, 0);
            tick();
            chk("R9 sp hold", {20'b0, sp_o}, {20'b0, exp_sp});
        end

        // R2 R3 R10: full push sweep wrapping past zero
        for (int i = 0; i <= WORDS; i++) begin
            logic [DW-1:0] d;
            d = 32'hA500_0000 ^ (i * 32'h0001_0003);
            drive(3'd1, 32'h77, 16'h5, d);
            chk("R2 push addr", {20'b0, mem_addr_o}, {20'b0, exp_sp});
            chk("R2 push we", {31'b0, mem_we_o}, 1);
            chk("R8 push re", {31'b0, mem_re_o}, 0);
            chk("R2 push wdata", mem_wdata_o, d);
            shadow[exp_sp[AW-1:1]] = d;
            tick();
            exp_sp = exp_sp - 12'd2;
            chk(i == WORDS - 1 ? "R10 push wrap" : "R3 push sp", {20'b0, sp_o}, {20'b0, exp_sp});
        end

        // R4 R10: pop sweep back, data returned in reverse order
        for (int i = 0; i <= WORDS; i++) begin
            logic [AW-1:0] a;
            a = exp_sp + 12'd2;
            drive(3'd2, 32'h0, 16'h0, 32'h1111);
            chk("R4 pop addr", {20'b0, mem_addr_o}, {20'b0, a});
            chk("R4 pop re", {31'b0, mem_re_o}, 1);
            chk("R8 pop we", {31'b0, mem_we_o}, 0);
            chk("R4 pop data", model[mem_addr_o[AW-1:1]], shadow[a[AW-1:1]]);
            tick();
            exp_sp = a;
            chk(a == 0 ? "R10 pop wrap" : "R4 pop sp", {20'b0, sp_o}, {20'b0, exp_sp});
        end

        // R5 R6 R7: displacement store then load over sign boundary
        foreach (bases[bi]) begin
            foreach (offs[oi]) begin
                logic [AW-1:0] a;
                logic [DW-1:0] d;
                a = ea(bases[bi], offs[oi]);
                d = {bases[bi][15:0], offs[oi]} ^ 32'h3C3C_0000;
                drive(3'd4, bases[bi], offs[oi], d);
                chk(offs[oi][15] ? "R7 store addr" : "R6 store addr", {20'b0, mem_addr_o}, {20'b0, a});
                chk("R6 store we", {31'b0, mem_we_o}, 1);
                chk("R8 store re", {31'b0, mem_re_o}, 0);
                chk("R6 store wdata", mem_wdata_o, d);
                tick();
                chk("R9 sp store", {20'b0, sp_o}, {20'b0, exp_sp});
                drive(3'd3, bases[bi], offs[oi], 32'h0);
                chk(offs[oi][15] ? "R7 load addr" : "R5 load addr", {20'b0, mem_addr_o}, {20'b0, a});
                chk("R5 load re", {31'b0, mem_re_o}, 1);
                chk("R8 load we", {31'b0, mem_we_o}, 0);
                chk("R5 load data", model[mem_addr_o[AW-1:1]], d);
                tick();
                chk("R9 sp load", {20'b0, sp_o}, {20'b0, exp_sp});
            end
        end

        drive(3'd0, 0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule